// File: doc/BRIEF.md
# Multi-core external interrupt router

The router takes a vector of level-sensitive interrupt inputs, tracks which of them are pending, masks them with per-input enable bits and delivers each enabled one to a single target core. Each core has a small set of parent interrupt lines. All inputs in one group of 32 share one parent line number, and a line is high while at least one input delivered to that core through that line is still in service.

Software reaches the block through a 32-bit word-addressed register port. It holds the enable words, a read-only raw pending image, per-core in-service status words that are cleared by writing 1, a per-input core routing table, a per-group line map and a spare array that is stored and read back only. The in-service status region is banked by core: the core index carried with each request picks the bank, not the address.

Delivery acts on edges of state. An input is delivered when it rises while enabled, when its enable bit goes from 0 to 1 while it is pending, or when its route changes while it is pending and enabled. It is withdrawn when it falls, when it is masked, or when its owning core clears it. An input that stays asserted after being cleared is not delivered again until it falls and rises again.

Top module: `irq_router`

## Requirements
- R1: After reset every enable, pending and in-service bit is zero, every input routes to core 0 through line 0, all `line_out` bits are low, and enable words read zero.
- R2: Region 1 (word address bits [8:6] = 1) word k bit b reads the input level of input 32k+b sampled at the previous clock edge, whether or not that input is enabled.
- R3: An input that rises while its enable bit (region 0, word k bit b) is clear sets no in-service bit and raises no line.
- R4: An enabled input that rises sets its in-service bit in its target core and drives `line_out[core*NUM_LINES + line]` high on the second clock edge after the input is sampled, where line is the map entry of its group.
- R5: A line stays high while any input delivered to that core and line remains in service, and drops only after the last such input leaves.
- R6: Writing an enable word delivers every bit that goes 0 to 1 and is pending, and withdraws every bit that goes 1 to 0.
- R7: Region 2 is write-1-to-clear: a written 1 clears an in-service bit only when the input is routed to the requesting core; a cleared input that stays asserted is not delivered again until it falls and rises.
- R8: A read of region 2 returns the in-service bits of the core given on `req_core`; inputs routed to other cores read zero.
- R9: Changing the route of a pending, enabled input moves it off the old core and delivers it to the new one.
- R10: Region 4 word i byte j sets the core of input 4i+j and region 3 word 0 byte g sets the line of group g; the value is the position of the lowest set bit of the byte, and a zero byte or a position at or above the core or line count selects 0. Reads return a byte with only bit (selected value) set; bytes of groups that do not exist read zero.
- R11: Region 5 words are stored and read back and have no effect on delivery.
- R12: Regions 6 and 7 and word indices beyond a region's size read zero and ignore writes.
- R13: Each read request is answered with `resp_valid` high on the next cycle, carrying the data as it was before that edge; writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt inputs |
| req_valid | input | 1 | Register request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 9 | Word address: [8:6] region, [5:0] word index |
| req_wdata | input | 32 | Write data |
| req_core | input | $clog2(NUM_CORES) | Requesting core, selects the status bank |
| resp_valid | output | 1 | Read data valid, one cycle after a read request |
| resp_rdata | output | 32 | Read data |
| line_out | output | NUM_CORES*NUM_LINES | Parent interrupt lines, core-major |

## Verification
A wrong in-service bit shows on `line_out` two edges after the event that should have set or cleared it, and in a status read of the owning core one cycle after the request. A wrong route or line map shows as a line raised on the wrong core or line number. The bench models every delivery rule at each edge and compares every line and every read response, so a stale or misplaced bit is seen within the first cycle it reaches a port.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RG_ENABLE = 3'd0,
    RG_PEND   = 3'd1,
    RG_STATUS = 3'd2,
    RG_LMAP   = 3'd3,
    RG_ROUTE  = 3'd4,
    RG_SPARE  = 3'd5
  } region_e;

  // lowest set bit of a byte; zero byte or position >= limit selects 0
  function automatic int unsigned pick_low(input logic [7:0] b, input int unsigned limit);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) if (b[i]) r = i;
    if (r >= limit) r = 0;
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_IN    = 64,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 4,
  localparam int WORDS  = NUM_IN / WORD_W,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [2:0]                          region,
  input  logic [5:0]                          widx,
  input  logic [WORD_W-1:0]                   wdata,
  output logic [NUM_IN-1:0]                   en_q,
  output logic [NUM_IN-1:0]                   en_d,
  output logic [NUM_IN-1:0][CORE_W-1:0]       route_q,
  output logic [NUM_IN-1:0][CORE_W-1:0]       route_d,
  output logic [WORDS-1:0][LINE_W-1:0]        lmap_q,
  output logic [WORDS-1:0][WORD_W-1:0]        spare_q
);
  localparam int ROUTE_WORDS = NUM_IN / 4;

  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    if (wr_en && region == RG_ENABLE && int'(widx) < WORDS)
      en_d[WORD_W*int'(widx) +: WORD_W] = wdata;
    if (wr_en && region == RG_ROUTE && int'(widx) < ROUTE_WORDS)
      for (int b = 0; b < 4; b++)
        route_d[int'(widx)*4 + b] = CORE_W'(pick_low(wdata[8*b +: 8], NUM_CORES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      lmap_q  <= '0;
      spare_q <= '0;
    end else begin
      en_q    <= en_d;
      route_q <= route_d;
      if (wr_en && region == RG_LMAP && widx == 6'd0)
        for (int g = 0; g < WORDS && g < 4; g++)
          lmap_q[g] <= LINE_W'(pick_low(wdata[8*g +: 8], NUM_LINES));
      if (wr_en && region == RG_SPARE && int'(widx) < WORDS)
        spare_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_router_pkg::*;
#(
  parameter int NUM_IN    = 64,
  parameter int NUM_CORES = 4,
  localparam int WORDS  = NUM_IN / WORD_W,
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             irq_in,
  input  logic [NUM_IN-1:0]             en_q,
  input  logic [NUM_IN-1:0]             en_d,
  input  logic [NUM_IN-1:0][CORE_W-1:0] route_q,
  input  logic [NUM_IN-1:0][CORE_W-1:0] route_d,
  input  logic                          clr_valid,
  input  logic [5:0]                    clr_word,
  input  logic [WORD_W-1:0]             clr_bits,
  input  logic [CORE_W-1:0]             clr_core,
  output logic [NUM_IN-1:0]             pend_q,
  output logic [NUM_IN-1:0]             act_q
);
  logic [NUM_IN-1:0] act_d;

  for (genvar n = 0; n < NUM_IN; n++) begin : g_in
    logic fresh, clr_hit;
    assign fresh   = (irq_in[n] & ~pend_q[n]) | (en_d[n] & ~en_q[n]) |
                     (route_d[n] != route_q[n]);
    assign clr_hit = clr_valid && int'(clr_word) == n / WORD_W &&
                     clr_bits[n % WORD_W] && route_q[n] == clr_core;
    always_comb begin
      if (!(irq_in[n] && en_d[n])) act_d[n] = 1'b0;
      else if (fresh)              act_d[n] = 1'b1;
      else if (clr_hit)            act_d[n] = 1'b0;
      else                         act_d[n] = act_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= irq_in;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/irq_line_agg.sv
module irq_line_agg
  import irq_router_pkg::*;
#(
  parameter int NUM_IN    = 64,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 4,
  localparam int WORDS  = NUM_IN / WORD_W,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int OUTS   = NUM_CORES * NUM_LINES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             act_q,
  input  logic [NUM_IN-1:0][CORE_W-1:0] route_q,
  input  logic [WORDS-1:0][LINE_W-1:0]  lmap_q,
  output logic [OUTS-1:0]               line_q
);
  logic [OUTS-1:0] line_d;

  always_comb begin
    line_d = '0;
    for (int n = 0; n < NUM_IN; n++)
      if (act_q[n])
        line_d[int'(route_q[n])*NUM_LINES + int'(lmap_q[n/WORD_W])] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_IN    = 64,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 4,
  localparam int WORDS  = NUM_IN / WORD_W,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int OUTS   = NUM_CORES * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IN-1:0]    irq_in,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [8:0]           req_waddr,
  input  logic [WORD_W-1:0]    req_wdata,
  input  logic [CORE_W-1:0]    req_core,
  output logic                 resp_valid,
  output logic [WORD_W-1:0]    resp_rdata,
  output logic [OUTS-1:0]      line_out
);
  localparam int ROUTE_WORDS = NUM_IN / 4;

  logic [2:0] region;
  logic [5:0] widx;
  logic       wr_en, rd_en;
  logic [NUM_IN-1:0]             en_q, en_d, pend_q, act_q;
  logic [NUM_IN-1:0][CORE_W-1:0] route_q, route_d;
  logic [WORDS-1:0][LINE_W-1:0]  lmap_q;
  logic [WORDS-1:0][WORD_W-1:0]  spare_q;
  logic [WORD_W-1:0]             rd_word;

  assign region = req_waddr[8:6];
  assign widx   = req_waddr[5:0];
  assign wr_en  = req_valid & req_write;
  assign rd_en  = req_valid & ~req_write;

  irq_cfg_regs #(.NUM_IN(NUM_IN), .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .region(region), .widx(widx),
    .wdata(req_wdata), .en_q(en_q), .en_d(en_d), .route_q(route_q),
    .route_d(route_d), .lmap_q(lmap_q), .spare_q(spare_q));

  irq_pend_track #(.NUM_IN(NUM_IN), .NUM_CORES(NUM_CORES)) u_trk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_q(en_q), .en_d(en_d),
    .route_q(route_q), .route_d(route_d),
    .clr_valid(wr_en && region == RG_STATUS), .clr_word(widx),
    .clr_bits(req_wdata), .clr_core(req_core),
    .pend_q(pend_q), .act_q(act_q));

  irq_line_agg #(.NUM_IN(NUM_IN), .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_agg (
    .clk(clk), .rst_n(rst_n), .act_q(act_q), .route_q(route_q),
    .lmap_q(lmap_q), .line_q(line_out));

  always_comb begin
    rd_word = '0;
    case (region)
      RG_ENABLE: if (int'(widx) < WORDS) rd_word = en_q[WORD_W*int'(widx) +: WORD_W];
      RG_PEND:   if (int'(widx) < WORDS) rd_word = pend_q[WORD_W*int'(widx) +: WORD_W];
      RG_STATUS: if (int'(widx) < WORDS)
                   for (int b = 0; b < WORD_W; b++)
                     rd_word[b] = act_q[WORD_W*int'(widx) + b] &&
                                  route_q[WORD_W*int'(widx) + b] == req_core;
      RG_LMAP:   if (widx == 6'd0)
                   for (int g = 0; g < WORDS && g < 4; g++)
                     rd_word[8*g +: 8] = 8'(1) << lmap_q[g];
      RG_ROUTE:  if (int'(widx) < ROUTE_WORDS)
                   for (int b = 0; b < 4; b++)
                     rd_word[8*b +: 8] = 8'(1) << route_q[int'(widx)*4 + b];
      RG_SPARE:  if (int'(widx) < WORDS) rd_word = spare_q[widx];
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rd_en;
      resp_rdata <= rd_en ? rd_word : '0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_IN = 64,
  parameter int OUTS   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              resp_valid,
  input logic [NUM_IN-1:0] irq_in,
  input logic [NUM_IN-1:0] pend_q,
  input logic [NUM_IN-1:0] en_q,
  input logic [NUM_IN-1:0] act_q,
  input logic [OUTS-1:0]   line_out
);
  // R13: every read is answered on the next cycle
  p_resp_after_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> resp_valid);
  // R13: no response without a read
  p_no_extra_resp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !resp_valid);
  // R2: raw pending follows the sampled input level
  p_pend_tracks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(irq_in));
  // R3: nothing is in service unless pending and enabled
  p_active_needs_pend_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q & ~(pend_q & en_q)) == '0);
  // R5: a raised line always has an in-service source one cycle earlier
  p_line_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_out != '0) |-> ($past(act_q) != '0));
endmodule

bind irq_router irq_router_chk #(.NUM_IN(NUM_IN), .OUTS(OUTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .resp_valid(resp_valid), .irq_in(irq_in), .pend_q(pend_q), .en_q(en_q),
  .act_q(act_q), .line_out(line_out));

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NI = 64, NC = 4, NL = 4, NW = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_waddr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_core = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic [15:0] line_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_router #(.NUM_IN(NI), .NUM_CORES(NC), .NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid),
    .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
    .req_core(req_core), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .line_out(line_out));

  // behavioural reference model
  bit m_pend[NI], m_en[NI], m_act[NI];
  int m_route[NI];
  int m_lmap[NW];
  logic [31:0] m_spare[NW];
  logic [15:0] m_line;
  bit m_rv;
  logic [31:0] m_rdata;

  function automatic int dec(input logic [7:0] b, input int lim);
    for (int i = 0; i < 8; i++) if (b[i]) return (i < lim) ? i : 0;
    return 0;
  endfunction

  function automatic logic [31:0] mread(input int rg, input int idx, input int core);
    logic [31:0] d = '0;
    case (rg)
      0: if (idx < NW) for (int b = 0; b < 32; b++) d[b] = m_en[idx*32+b];
      1: if (idx < NW) for (int b = 0; b < 32; b++) d[b] = m_pend[idx*32+b];
      2: if (idx < NW) for (int b = 0; b < 32; b++) d[b] = m_act[idx*32+b] && m_route[idx*32+b] == core;
      3: if (idx == 0) for (int g = 0; g < NW; g++) d[8*g + m_lmap[g]] = 1'b1;
      4: if (idx < NI/4) for (int b = 0; b < 4; b++) d[8*b + m_route[idx*4+b]] = 1'b1;
      5: if (idx < NW) d = m_spare[idx];
      default: d = '0;
    endcase
    return d;
  endfunction

  always @(posedge clk) begin
    bit en_n[NI];
    int ro_n[NI];
    bit clr[NI];
    logic [15:0] nl;
    int rg, idx;
    if (!rst_n) begin
      for (int n = 0; n < NI; n++) begin m_pend[n]=0; m_en[n]=0; m_act[n]=0; m_route[n]=0; end
      for (int g = 0; g < NW; g++) begin m_lmap[g]=0; m_spare[g]='0; end
      m_line = '0; m_rv = 0; m_rdata = '0;
    end else begin
      nl = '0;
      for (int n = 0; n < NI; n++) if (m_act[n]) nl[m_route[n]*NL + m_lmap[n/32]] = 1'b1;
      for (int n = 0; n < NI; n++) begin en_n[n]=m_en[n]; ro_n[n]=m_route[n]; clr[n]=0; end
      rg = int'(req_waddr[8:6]); idx = int'(req_waddr[5:0]);
      m_rv = req_valid && !req_write;
      if (m_rv) m_rdata = mread(rg, idx, int'(req_core));
      if (req_valid && req_write) begin
        case (rg)
          0: if (idx < NW) for (int b = 0; b < 32; b++) en_n[idx*32+b] = req_wdata[b];
          2: if (idx < NW) for (int b = 0; b < 32; b++)
               clr[idx*32+b] = req_wdata[b] && m_route[idx*32+b] == int'(req_core);
          3: if (idx == 0) for (int g = 0; g < NW; g++) m_lmap[g] = dec(req_wdata[8*g +: 8], NL);
          4: if (idx < NI/4) for (int b = 0; b < 4; b++) ro_n[idx*4+b] = dec(req_wdata[8*b +: 8], NC);
          5: if (idx < NW) m_spare[idx] = req_wdata;
          default: ;
        endcase
      end
      for (int n = 0; n < NI; n++) begin
        if (!(irq_in[n] && en_n[n])) m_act[n] = 0;
        else if ((irq_in[n] && !m_pend[n]) || (en_n[n] && !m_en[n]) || ro_n[n] != m_route[n]) m_act[n] = 1;
        else if (clr[n]) m_act[n] = 0;
        m_pend[n] = irq_in[n]; m_en[n] = en_n[n]; m_route[n] = ro_n[n];
      end
      m_line = nl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // compare on every cycle against the model, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 line_out vs model", 32'(line_out), 32'(m_line));
    chk("R13 resp_valid vs model", 32'(resp_valid), 32'(m_rv));
    if (m_rv) chk("R13 resp_rdata vs model", resp_rdata, m_rdata);
  end

  task automatic wr(input int rg, input int idx, input logic [31:0] d, input int core);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_waddr = {3'(rg), 6'(idx)}; req_wdata = d; req_core = 2'(core);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int rg, input int idx, input int core, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_waddr = {3'(rg), 6'(idx)}; req_core = 2'(core);
    @(negedge clk);
    d = resp_rdata; req_valid = 0;
  endtask

  task automatic set_irq(input int n, input logic v);
    @(negedge clk); irq_in[n] = v;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 line_out after reset", 32'(line_out), 32'h0);
    rd(0, 0, 0, d); chk("R1 enable word 0 after reset", d, 32'h0);
    rd(4, 0, 0, d); chk("R1 route word 0 after reset", d, 32'h01010101);

    set_irq(3, 1); settle();
    rd(1, 0, 0, d); chk("R2 pending of disabled input", d, 32'h8);
    rd(2, 0, 0, d); chk("R3 status of disabled input", d, 32'h0);
    chk("R3 no line for disabled input", 32'(line_out), 32'h0);

    wr(0, 0, 32'h8, 0); settle();
    chk("R6 unmask delivers pending", 32'(line_out), 32'h0001);
    rd(2, 0, 0, d); chk("R6 status after unmask", d, 32'h8);

    wr(4, 1, 32'h00800400, 0);
    rd(4, 1, 0, d); chk("R10 route readback one-hot", d, 32'h01010401);
    wr(3, 0, 32'h00000800, 0);
    rd(3, 0, 0, d); chk("R10 line map readback", d, 32'h00000801);

    wr(4, 9, 32'h00000200, 0);
    wr(0, 1, 32'h20, 0);
    set_irq(37, 1); settle();
    chk("R4 delivery to core1 line3", 32'(line_out), 32'h0081);
    rd(2, 1, 1, d); chk("R8 status bank core1", d, 32'h20);
    rd(2, 1, 0, d); chk("R8 status bank core0", d, 32'h0);

    wr(4, 9, 32'h00020200, 0);
    wr(0, 1, 32'h60, 0);
    set_irq(38, 1); settle();
    chk("R5 two sources one line", 32'(line_out), 32'h0081);
    set_irq(37, 0); settle();
    chk("R5 line held by remaining source", 32'(line_out), 32'h0081);
    rd(2, 1, 1, d); chk("R5 status after first leaves", d, 32'h40);
    set_irq(38, 0); settle();
    chk("R5 line drops after last source", 32'(line_out), 32'h0001);

    wr(2, 0, 32'h8, 1); settle();
    chk("R7 clear from other core ignored", 32'(line_out), 32'h0001);
    wr(2, 0, 32'h8, 0); settle();
    chk("R7 clear from owning core", 32'(line_out), 32'h0000);
    rd(1, 0, 0, d); chk("R7 still pending after clear", d, 32'h8);
    settle();
    chk("R7 no redelivery while held", 32'(line_out), 32'h0000);
    set_irq(3, 0); set_irq(3, 1); settle();
    chk("R7 redelivery on new edge", 32'(line_out), 32'h0001);

    wr(4, 0, 32'h08000000, 0); settle();
    chk("R9 reroute to core3", 32'(line_out), 32'h1000);
    rd(2, 0, 3, d); chk("R9 status on new core", d, 32'h8);

    wr(0, 0, 32'h0, 0); settle();
    chk("R6 mask withdraws", 32'(line_out), 32'h0000);
    rd(2, 0, 3, d); chk("R6 status after mask", d, 32'h0);

    wr(5, 1, 32'hdeadbeef, 0);
    rd(5, 1, 0, d); chk("R11 spare readback", d, 32'hdeadbeef);
    wr(0, 0, 32'h8, 0); settle();
    wr(5, 0, 32'hffffffff, 0); settle();
    chk("R11 spare write leaves delivery", 32'(line_out), 32'h1000);

    wr(6, 0, 32'hffffffff, 0);
    rd(6, 0, 0, d); chk("R12 undefined region reads zero", d, 32'h0);
    wr(0, 5, 32'hffffffff, 0);
    rd(0, 0, 0, d); chk("R12 out-of-range write ignored", d, 32'h8);
    rd(0, 5, 0, d); chk("R12 out-of-range read zero", d, 32'h0);
    settle();
    chk("R12 lines unchanged", 32'(line_out), 32'h1000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule